// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block sits in front of the address translation unit and the cache of a processor core. Every request carries a 32-bit virtual address, the current processor mode, an access kind (read or write) and a set of control bits. The block sorts the address into one of six areas. It refuses any user-mode access that lies outside the lower half of the address space.

For each access it works out three things. First, whether the address must be sent to the translation lookaside buffer. Second, whether the access may go through the cache. Third, which write policy applies. For areas that are never translated, it forms the 29-bit physical address directly.

The page cacheability bit from a translation lookup is taken as an input. The lookup itself and the cache are not part of this block. Results are registered and appear one cycle after the request strobe.

Top module: `vad_region_decoder`

## Requirements
- R1: The area code is chosen by address bits 31:29. Values 0-3 (0x00000000-0x7FFFFFFF) give code 5 (U0) in user mode and code 0 (P0) in privileged mode. Value 4 gives code 1 (P1), 5 gives code 2 (P2), 6 gives code 3 (P3) and 7 gives code 4 (P4).
- R2: In user mode, an address with bit 31 set raises the address-error flag. A privileged access never raises it.
- R3: An error-free access to P0, P3 or U0 with the MMU enable input high asserts the translate request and returns physical address 0. Every other access leaves the translate request low.
- R4: An error-free access that is not translated returns virtual address bits 28:0 as its physical address, in every area and whatever the MMU enable input is.
- R5: In P1, the cacheable flag equals the cache enable input. The write-through flag is high only for a cacheable write with the copy-back control input low.
- R6: In P0, P3 and U0, the access is cacheable when the cache enable input is high and either the MMU is disabled or the page cacheability input is high. The write-through flag is high only for a cacheable write with the write-through control input high.
- R7: P2 and P4 are never cacheable and never write-through. The control-register select output is high only for error-free P4 accesses.
- R8: An address error forces the translate request, cacheable, write-through and control-register select outputs to 0, and the physical address to 0.
- R9: After reset, the response strobe and all result outputs are 0. The response strobe is high exactly in the cycle after a request strobe. Result outputs hold their values while no request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| user_mode | input | 1 | 1 = user mode, 0 = privileged |
| is_write | input | 1 | 1 = write access, 0 = read |
| mmu_en | input | 1 | Address translation enable |
| cache_en | input | 1 | Global cache enable |
| p1_copyback | input | 1 | P1 write policy: 1 = copy-back, 0 = write-through |
| map_wthru | input | 1 | P0/P3/U0 write policy: 1 = write-through |
| page_cache | input | 1 | Cacheability bit of the page from the translation lookup |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| area | output | 3 | Area code (see R1) |
| addr_err | output | 1 | Address error |
| xlat_req | output | 1 | Translation request |
| paddr | output | 29 | Physical address for untranslated accesses |
| cacheable | output | 1 | Access may use the cache |
| wr_thru | output | 1 | Write-through policy applies |
| regsp_sel | output | 1 | Access targets the on-chip control register space |

## Verification
The assertions assume that reset is held low for the first cycles. They also assume that the address, mode, access kind and control inputs carry known values in every cycle where the request strobe is high. The implications that look at the cycle after a request also assume that no input is sampled half-changed at the clock edge. The bench changes all inputs only on the falling clock edge, so each request is captured whole. It sweeps every top-bit value against every combination of mode, access kind and control bits, with address patterns that include both ends of each area.

// File: rtl/vad_pkg.sv
package vad_pkg;

   localparam int unsigned SEG_BITS = 3;

   typedef enum logic [2:0] {
      AREA_P0 = 3'd0,
      AREA_P1 = 3'd1,
      AREA_P2 = 3'd2,
      AREA_P3 = 3'd3,
      AREA_P4 = 3'd4,
      AREA_U0 = 3'd5
   } area_e;

   function automatic logic is_mappable(area_e a);
      return (a == AREA_P0) || (a == AREA_P3) || (a == AREA_U0);
   endfunction

endpackage

// File: rtl/vad_area_classify.sv
module vad_area_classify
   import vad_pkg::*;
#(
   parameter int unsigned SEG_W = 3
) (
   input  logic [SEG_W-1:0] seg,
   input  logic             user_mode,
   output area_e            area
);

   generate
      if (SEG_W != SEG_BITS) begin : g_bad_seg
         $error("vad_area_classify: SEG_W must equal SEG_BITS");
      end
   endgenerate

   always_comb begin
      unique case (seg)
         3'd4:    area = AREA_P1;
         3'd5:    area = AREA_P2;
         3'd6:    area = AREA_P3;
         3'd7:    area = AREA_P4;
         default: area = user_mode ? AREA_U0 : AREA_P0;
      endcase
   end

endmodule

// File: rtl/vad_access_check.sv
module vad_access_check
   import vad_pkg::*;
(
   input  area_e area,
   input  logic  user_mode,
   output logic  addr_err
);

   always_comb begin
      addr_err = user_mode && (area != AREA_U0);
   end

endmodule

// File: rtl/vad_attr_gen.sv
module vad_attr_gen
   import vad_pkg::*;
#(
   parameter int unsigned PA_W = 29
) (
   input  area_e           area,
   input  logic            addr_err,
   input  logic            is_write,
   input  logic            mmu_en,
   input  logic            cache_en,
   input  logic            p1_copyback,
   input  logic            map_wthru,
   input  logic            page_cache,
   input  logic [PA_W-1:0] low_addr,
   output logic            xlat,
   output logic            cach,
   output logic            wthru,
   output logic            regsp,
   output logic [PA_W-1:0] paddr
);

   logic mappable;
   logic cach_raw;
   logic wt_policy;

   always_comb begin
      mappable = is_mappable(area);
      xlat     = !addr_err && mappable && mmu_en;
   end

   always_comb begin
      cach_raw  = 1'b0;
      wt_policy = 1'b0;
      unique case (area)
         AREA_P1: begin
            cach_raw  = cache_en;
            wt_policy = !p1_copyback;
         end
         AREA_P0, AREA_P3, AREA_U0: begin
            cach_raw  = cache_en && (!mmu_en || page_cache);
            wt_policy = map_wthru;
         end
         default: begin
            cach_raw  = 1'b0;
            wt_policy = 1'b0;
         end
      endcase
   end

   always_comb begin
      cach  = cach_raw && !addr_err;
      wthru = cach && is_write && wt_policy;
      regsp = !addr_err && (area == AREA_P4);
      paddr = (addr_err || xlat) ? '0 : low_addr;
   end

endmodule

// File: rtl/vad_region_decoder.sv
module vad_region_decoder
   import vad_pkg::*;
#(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 29,
   parameter bit          RESET_DATA = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [VA_W-1:0] vaddr,
   input  logic            user_mode,
   input  logic            is_write,
   input  logic            mmu_en,
   input  logic            cache_en,
   input  logic            p1_copyback,
   input  logic            map_wthru,
   input  logic            page_cache,
   output logic            rsp_valid,
   output logic [2:0]      area,
   output logic            addr_err,
   output logic            xlat_req,
   output logic [PA_W-1:0] paddr,
   output logic            cacheable,
   output logic            wr_thru,
   output logic            regsp_sel
);

   localparam int unsigned SEG_W = VA_W - PA_W;

   generate
      if (SEG_W != SEG_BITS) begin : g_bad_width
         $error("vad_region_decoder: VA_W - PA_W must be 3");
      end
   endgenerate

   area_e           c_area;
   logic            c_err;
   logic            c_xlat;
   logic            c_cach;
   logic            c_wthru;
   logic            c_regsp;
   logic [PA_W-1:0] c_paddr;

   vad_area_classify #(.SEG_W(SEG_W)) u_classify (
      .seg       (vaddr[VA_W-1:PA_W]),
      .user_mode (user_mode),
      .area      (c_area)
   );

   vad_access_check u_check (
      .area      (c_area),
      .user_mode (user_mode),
      .addr_err  (c_err)
   );

   vad_attr_gen #(.PA_W(PA_W)) u_attr (
      .area        (c_area),
      .addr_err    (c_err),
      .is_write    (is_write),
      .mmu_en      (mmu_en),
      .cache_en    (cache_en),
      .p1_copyback (p1_copyback),
      .map_wthru   (map_wthru),
      .page_cache  (page_cache),
      .low_addr    (vaddr[PA_W-1:0]),
      .xlat        (c_xlat),
      .cach        (c_cach),
      .wthru       (c_wthru),
      .regsp       (c_regsp),
      .paddr       (c_paddr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= req_valid;
   end

   generate
      if (RESET_DATA) begin : g_data_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               area      <= '0;
               addr_err  <= 1'b0;
               xlat_req  <= 1'b0;
               paddr     <= '0;
               cacheable <= 1'b0;
               wr_thru   <= 1'b0;
               regsp_sel <= 1'b0;
            end else if (req_valid) begin
               area      <= c_area;
               addr_err  <= c_err;
               xlat_req  <= c_xlat;
               paddr     <= c_paddr;
               cacheable <= c_cach;
               wr_thru   <= c_wthru;
               regsp_sel <= c_regsp;
            end
         end
      end else begin : g_data_free
         always_ff @(posedge clk) begin
            if (req_valid) begin
               area      <= c_area;
               addr_err  <= c_err;
               xlat_req  <= c_xlat;
               paddr     <= c_paddr;
               cacheable <= c_cach;
               wr_thru   <= c_wthru;
               regsp_sel <= c_regsp;
            end
         end
      end
   endgenerate

   AST_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && user_mode && vaddr[VA_W-1] |=> rsp_valid && addr_err); // R2

   AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !user_mode |=> !addr_err); // R2

   AST_P1_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !user_mode && (vaddr[VA_W-1:PA_W] == 3'd4)
      |=> !xlat_req && (paddr == $past(vaddr[PA_W-1:0]))); // R4

   AST_UNCACHED_AREAS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && ((area == 3'd2) || (area == 3'd4)) |-> !cacheable && !wr_thru && !xlat_req); // R7

   AST_WT_NEEDS_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && wr_thru |-> cacheable); // R6

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && addr_err |-> !xlat_req && !cacheable && !wr_thru && !regsp_sel && (paddr == '0)); // R8

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R9

   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && $stable(area) && $stable(paddr)); // R9

endmodule

// File: tb/vad_region_decoder_bench.sv
module vad_region_decoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic [2:0]  area;
      logic        err;
      logic        xlat;
      logic [28:0] paddr;
      logic        cach;
      logic        wthru;
      logic        regsp;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] vaddr = '0;
   logic        user_mode = 1'b0, is_write = 1'b0, mmu_en = 1'b0, cache_en = 1'b0;
   logic        p1_copyback = 1'b0, map_wthru = 1'b0, page_cache = 1'b0;
   logic        rsp_valid, addr_err, xlat_req, cacheable, wr_thru, regsp_sel;
   logic [2:0]  area;
   logic [28:0] paddr;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];
   exp_t last_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   vad_region_decoder u_vad_region_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
      .user_mode(user_mode), .is_write(is_write), .mmu_en(mmu_en),
      .cache_en(cache_en), .p1_copyback(p1_copyback), .map_wthru(map_wthru),
      .page_cache(page_cache), .rsp_valid(rsp_valid), .area(area),
      .addr_err(addr_err), .xlat_req(xlat_req), .paddr(paddr),
      .cacheable(cacheable), .wr_thru(wr_thru), .regsp_sel(regsp_sel)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [31:0] a, input logic usr, input logic wr,
                                  input logic mmu, input logic ce, input logic cb,
                                  input logic wt, input logic pc);
      exp_t e;
      logic mappable, pol;
      e = '0;
      case (a[31:29])
         3'd4: e.area = 3'd1;
         3'd5: e.area = 3'd2;
         3'd6: e.area = 3'd3;
         3'd7: e.area = 3'd4;
         default: e.area = usr ? 3'd5 : 3'd0;
      endcase
      e.err = usr && a[31];
      mappable = (e.area == 3'd0) || (e.area == 3'd3) || (e.area == 3'd5);
      pol = 1'b0;
      if (!e.err) begin
         e.xlat = mappable && mmu;
         if (e.area == 3'd1) begin
            e.cach = ce;
            pol = !cb;
         end else if (mappable) begin
            e.cach = ce && (!mmu || pc);
            pol = wt;
         end
         e.wthru = e.cach && wr && pol;
         e.regsp = (e.area == 3'd4);
         e.paddr = e.xlat ? 29'd0 : a[28:0];
      end
      return e;
   endfunction

   task automatic drive(input logic [31:0] a, input logic [6:0] ctl);
      @(negedge clk);
      req_valid   = 1'b1;
      vaddr       = a;
      user_mode   = ctl[0];
      mmu_en      = ctl[1];
      cache_en    = ctl[2];
      page_cache  = ctl[3];
      is_write    = ctl[4];
      p1_copyback = ctl[5];
      map_wthru   = ctl[6];
      last_exp    = model(a, ctl[0], ctl[4], ctl[1], ctl[2], ctl[5], ctl[6], ctl[3]);
      q.push_back(last_exp);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: pops one expected item per response strobe
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         string tc, tx;
         if (q.size() == 0) begin
            chk("R9 unexpected response", 32'd1, 32'd0);
         end else begin
            e = q.pop_front();
            tc = e.err ? "R8" : (e.area == 3'd1) ? "R5" :
                 ((e.area == 3'd2) || (e.area == 3'd4)) ? "R7" : "R6";
            tx = e.err ? "R8" : "R3";
            chk("R1 area",           {29'd0, area},      {29'd0, e.area});
            chk("R2 addr_err",       {31'd0, addr_err},  {31'd0, e.err});
            chk({tx, " xlat_req"},   {31'd0, xlat_req},  {31'd0, e.xlat});
            chk(e.err ? "R8 paddr" : e.xlat ? "R3 paddr" : "R4 paddr",
                {3'd0, paddr}, {3'd0, e.paddr});
            chk({tc, " cacheable"},  {31'd0, cacheable}, {31'd0, e.cach});
            chk({tc, " wr_thru"},    {31'd0, wr_thru},   {31'd0, e.wthru});
            chk(e.err ? "R8 regsp_sel" : "R7 regsp_sel", {31'd0, regsp_sel}, {31'd0, e.regsp});
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk("R9 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R9 reset area",      {29'd0, area},      32'd0);
      chk("R9 reset paddr",     {3'd0, paddr},      32'd0);
      chk("R9 reset flags", {26'd0, addr_err, xlat_req, cacheable, wr_thru, regsp_sel, 1'b0}, 32'd0);

      // Area boundaries in both modes (R1, R2)
      drive(32'h7FFF_FFFF, 7'b0000001);
      drive(32'h8000_0000, 7'b0000001);
      drive(32'h7FFF_FFFF, 7'b0000000);
      drive(32'h8000_0000, 7'b0000100);
      drive(32'h9FFF_FFFF, 7'b0010100);
      drive(32'hA000_0000, 7'b0000100);
      drive(32'hBFFF_FFFF, 7'b0000110);
      drive(32'hC000_0000, 7'b1011110);
      drive(32'hDFFF_FFFF, 7'b1010100);
      drive(32'hE000_0000, 7'b0000110);
      drive(32'hFFFF_FFFF, 7'b0000111);
      drive(32'h0000_0000, 7'b1011111);

      // R9: hold while idle
      idle();
      idle();
      @(negedge clk);
      chk("R9 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R9 idle hold area", {29'd0, area}, {29'd0, last_exp.area});
      chk("R9 idle hold paddr", {3'd0, paddr}, {3'd0, last_exp.paddr});

      // Full sweep of segment x controls
      for (int s = 0; s < 8; s++) begin
         for (int c = 0; c < 128; c++) begin
            logic [28:0] pat;
            pat = 29'((c * 32'h0ABC_DEF1) ^ (s * 32'h0135_7913));
            if (c == 5)  pat = '0;
            if (c == 77) pat = '1;
            drive({s[2:0], pat}, c[6:0]);
         end
         idle();
      end
      idle();
      repeat (3) @(negedge clk);
      chk("R9 all responses seen", q.size(), 32'd0);
      summary();
      $finish;
   end

endmodule